// File: doc/BRIEF.md
# Bus Cycle Termination Generator

This block decides when an external bus cycle ends. The bus master signals a new cycle with a one-clock start strobe while it holds one of several active-low chip selects low. Each chip-select region has its own configuration: a flag that enables automatic termination and a 4-bit wait-state count. In automatic mode the block counts the programmed wait states and then raises a one-clock cycle-complete pulse. In external mode it waits for a shared, active-low, wired acknowledge line that any slow or expansion device may pull low. That line is asynchronous, so it is synchronised before use.

In automatic mode an external acknowledge that arrives before the count runs out also ends the cycle, whichever comes first. If the master releases the chip select before the cycle completes, the cycle is abandoned without a pulse. The region number and its configuration are captured at the start strobe, so a configuration change in the middle of a cycle does not affect it.

Top module: `bct_ta_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `cyc_done` is low.
- R2: A cycle starts only when `cyc_start` is high while the block is idle and at least one `cs_n` bit is low. When several bits are low, the lowest-numbered one selects the region. A strobe with every `cs_n` bit high is ignored.
- R3: With auto mode on for the region and a wait value N, `cyc_done` is high in the (N+1)-th clock cycle after the clock edge that samples the start. A wait of 0 completes in the first cycle after that edge.
- R4: `cyc_done` is high for exactly one clock per started cycle. It stays low until the chip select is released and a new cycle is started.
- R5: With auto mode off for the region, the cycle ends only on the external acknowledge. If `ext_ack_n` is low at clock edge A, `cyc_done` is high in the cycle that follows edge A+1, which is two synchroniser stages later.
- R6: With auto mode on, an external acknowledge whose synchronised arrival comes before the end of the count ends the cycle at that earlier point.
- R7: If the selected region's `cs_n` goes high before completion, the cycle is abandoned and no `cyc_done` pulse is produced. A later start reloads the count from scratch.
- R8: An external acknowledge while no cycle is in progress produces no `cyc_done`.
- R9: A `cyc_start` strobe during a cycle in progress is ignored. The region and the count of that cycle are unchanged.
- R10: Region i takes its auto enable from `cfg_auto_en[i]` and its wait value from `cfg_wait[i*4 +: 4]`. The regions are independent of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe marking the start of a bus cycle |
| cs_n | input | NUM_CS | Active-low chip selects, one per region |
| cfg_auto_en | input | NUM_CS | Per-region auto-termination enable |
| cfg_wait | input | NUM_CS*WAIT_W | Per-region wait-state counts, packed by region |
| ext_ack_n | input | 1 | Shared asynchronous active-low external acknowledge |
| cyc_done | output | 1 | One-clock cycle-complete pulse to the master |

## Verification
The assertions assume the following about the inputs:
- `cyc_start` is a single-cycle strobe.
- The master holds the selected chip select low until it sees completion or decides to abandon the cycle.
- `ext_ack_n` returns high before the next cycle can see it.

The stimulus follows these assumptions. It changes inputs only on the falling clock edge. After every cycle it releases the chip select and the acknowledge together, then waits four idle clocks so that the synchroniser has drained before the next start.

// File: rtl/bct_pkg.sv
package bct_pkg;

   // Termination state of the current bus cycle.
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // no cycle in progress
      ST_WAIT = 2'd1,   // counting wait states or waiting for external ack
      ST_HOLD = 2'd2    // completed, waiting for chip select release
   } bct_state_e;

   // Configuration captured for the cycle in progress.
   typedef struct packed {
      logic       auto_en;
      logic [3:0] wait_cnt;
   } bct_region_cfg_t;

endpackage

// File: rtl/bct_ack_sync.sv
module bct_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_ack_n,
   output logic ack_seen
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bct_ack_sync: STAGES must be at least 2");
      end
   endgenerate

   // Chain resets to the inactive (high) level of the line.
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b1;
      else        chain_q[0] <= ext_ack_n;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b1;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign ack_seen = ~chain_q[STAGES-1];

   // R5: the last stage carries the previous value of the stage before it.
   p_sync_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chain_q[STAGES-1] == $past(chain_q[STAGES-2]));

endmodule

// File: rtl/bct_region_sel.sv
module bct_region_sel #(
   parameter int NUM_CS = 4,
   parameter int WAIT_W = 4,
   localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic [NUM_CS-1:0]        cs_n,
   input  logic [NUM_CS-1:0]        cfg_auto_en,
   input  logic [NUM_CS*WAIT_W-1:0] cfg_wait,
   output logic                     any_sel,
   output logic [IDX_W-1:0]         sel_idx,
   output logic                     sel_auto,
   output logic [WAIT_W-1:0]        sel_wait
);

   generate
      if (NUM_CS < 1) begin : g_bad_cs
         $error("bct_region_sel: NUM_CS must be at least 1");
      end
      if (WAIT_W < 1) begin : g_bad_w
         $error("bct_region_sel: WAIT_W must be at least 1");
      end
   endgenerate

   // Priority chain: the lowest-numbered asserted select wins.
   logic [NUM_CS:0]   none_below;
   logic [NUM_CS-1:0] grant;

   assign none_below[0] = 1'b1;

   generate
      for (genvar g = 0; g < NUM_CS; g++) begin : g_prio
         assign grant[g]        = none_below[g] & ~cs_n[g];
         assign none_below[g+1] = none_below[g] &  cs_n[g];
      end
   endgenerate

   assign any_sel = ~none_below[NUM_CS];

   always_comb begin
      sel_idx  = '0;
      sel_auto = 1'b0;
      sel_wait = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (grant[i]) begin
            sel_idx  = IDX_W'(i);
            sel_auto = cfg_auto_en[i];
            sel_wait = cfg_wait[i*WAIT_W +: WAIT_W];
         end
      end
   end

endmodule

// File: rtl/bct_wait_cnt.sv
module bct_wait_cnt #(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] load_val,
   input  logic              dec,
   output logic              zero
);

   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R3: each enabled step lowers the count by exactly one.
   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R3: a load takes the new value on the next edge.
   p_count_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/bct_ta_gen.sv
module bct_ta_gen
   import bct_pkg::*;
#(
   parameter int NUM_CS      = 4,
   parameter int WAIT_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cyc_start,
   input  logic [NUM_CS-1:0]        cs_n,
   input  logic [NUM_CS-1:0]        cfg_auto_en,
   input  logic [NUM_CS*WAIT_W-1:0] cfg_wait,
   input  logic                     ext_ack_n,
   output logic                     cyc_done
);

   localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

   generate
      if (NUM_CS > (1 << IDX_W)) begin : g_bad_idx
         $error("bct_ta_gen: region index too narrow");
      end
      if (WAIT_W > 16) begin : g_bad_wait
         $error("bct_ta_gen: WAIT_W above 16 is not supported");
      end
   endgenerate

   // Synchronised external acknowledge.
   logic ack_seen;

   bct_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_ack_n (ext_ack_n),
      .ack_seen  (ack_seen)
   );

   // Region decode at the start strobe.
   logic              any_sel;
   logic [IDX_W-1:0]  sel_idx;
   logic              sel_auto;
   logic [WAIT_W-1:0] sel_wait;

   bct_region_sel #(.NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) u_sel (
      .cs_n        (cs_n),
      .cfg_auto_en (cfg_auto_en),
      .cfg_wait    (cfg_wait),
      .any_sel     (any_sel),
      .sel_idx     (sel_idx),
      .sel_auto    (sel_auto),
      .sel_wait    (sel_wait)
   );

   // Cycle state.
   bct_state_e       state_q, state_d;
   logic [IDX_W-1:0] cur_idx_q;
   logic             auto_q;

   logic start_ok;
   logic held;
   logic fire;
   logic cnt_zero;
   logic cnt_dec;

   assign start_ok = cyc_start && any_sel && (state_q == ST_IDLE);
   assign held     = ~cs_n[cur_idx_q];
   assign fire     = (state_q == ST_WAIT) && held &&
                     ((auto_q && cnt_zero) || ack_seen);
   assign cnt_dec  = (state_q == ST_WAIT) && held && auto_q && !fire;

   bct_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_ok),
      .load_val (sel_wait),
      .dec      (cnt_dec),
      .zero     (cnt_zero)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_ok) state_d = ST_WAIT;
         ST_WAIT: begin
            if (!held)     state_d = ST_IDLE;
            else if (fire) state_d = ST_HOLD;
         end
         ST_HOLD: if (!held) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cur_idx_q <= '0;
         auto_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start_ok) begin
            cur_idx_q <= sel_idx;
            auto_q    <= sel_auto;
         end
      end
   end

   assign cyc_done = fire;

   // R4: completion is a single-clock pulse.
   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> !cyc_done);

   // R7: completion only while some chip select is still asserted.
   p_done_cs_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |-> !(&cs_n));

   // R5: in external mode, completion needs the synchronised acknowledge.
   p_manual_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_done && !auto_q) |-> ack_seen);

   // R2: an accepted start moves the block into the waiting state.
   p_start_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !(&cs_n) && state_q == ST_IDLE) |=> (state_q == ST_WAIT));

   // R9: a strobe during a cycle leaves the captured region unchanged.
   p_busy_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(cur_idx_q));

endmodule

// File: tb/bct_ta_gen_tb.sv
`timescale 1ns/1ps
module bct_ta_gen_tb;

   localparam int NCS = 2;
   localparam int WW  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cyc_start = 1'b0;
   logic [NCS-1:0]  cs_n = '1;
   logic [NCS-1:0]  cfg_auto_en = '0;
   logic [NCS*WW-1:0] cfg_wait = '0;
   logic            ext_ack_n = 1'b1;
   logic            cyc_done;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   bct_ta_gen #(.NUM_CS(NCS), .WAIT_W(WW), .SYNC_STAGES(2)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_start   (cyc_start),
      .cs_n        (cs_n),
      .cfg_auto_en (cfg_auto_en),
      .cfg_wait    (cfg_wait),
      .ext_ack_n   (ext_ack_n),
      .cyc_done    (cyc_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Run one cycle and return the sample index of the first completion
   // (0 when none) and the number of completion samples seen.
   task automatic run_cycle(input logic [NCS-1:0] csv, input int ack_at,
                            input int abort_at, input int restart_at,
                            output int first, output int cnt);
      first = 0;
      cnt   = 0;
      @(negedge clk);
      cs_n = csv;
      cyc_start = 1'b1;
      @(negedge clk);
      cyc_start = 1'b0;
      for (int k = 1; k <= 40; k++) begin
         if (cyc_done) begin
            cnt++;
            if (first == 0) first = k;
         end
         if (k == ack_at)   ext_ack_n = 1'b0;
         if (k == abort_at) cs_n = '1;
         if (k == restart_at) begin
            cyc_start = 1'b1;
            cs_n[0]   = 1'b0;
         end else begin
            cyc_start = 1'b0;
         end
         @(negedge clk);
      end
      cs_n = '1;
      ext_ack_n = 1'b1;
      cyc_start = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      int first, cnt, exp;

      // R1: output low during reset and right after release.
      repeat (3) @(negedge clk);
      chk(cyc_done == 1'b0, "R1 in reset", int'(cyc_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cyc_done == 1'b0, "R1 after reset", int'(cyc_done), 0);

      // R3 / R4 / R10: auto sweep over every wait value in both regions.
      for (int r = 0; r < NCS; r++) begin
         for (int w = 0; w < 16; w++) begin
            cfg_auto_en = '1;
            cfg_wait = '0;
            cfg_wait[r*WW +: WW] = WW'(w);
            cfg_wait[(1-r)*WW +: WW] = WW'(15 - w);
            run_cycle(~(NCS'(1) << r), 0, 0, 0, first, cnt);
            chk(first == w + 1, "R3 R10 auto latency", first, w + 1);
            chk(cnt == 1, "R4 single pulse", cnt, 1);
         end
      end

      // R5: external mode, acknowledge at several points.
      for (int r = 0; r < NCS; r++) begin
         for (int d = 1; d <= 6; d++) begin
            cfg_auto_en = '0;
            cfg_auto_en[1-r] = 1'b1;
            cfg_wait = '0;
            run_cycle(~(NCS'(1) << r), d, 0, 0, first, cnt);
            chk(first == d + 2, "R5 R10 external latency", first, d + 2);
            chk(cnt == 1, "R4 R5 single pulse", cnt, 1);
         end
      end

      // R5: external mode without any acknowledge never completes.
      cfg_auto_en = '0;
      run_cycle(2'b10, 0, 0, 0, first, cnt);
      chk(cnt == 0, "R5 no ack no done", cnt, 0);

      // R6: auto mode with external acknowledge: earlier of the two wins.
      for (int w = 0; w < 16; w += 3) begin
         for (int d = 1; d <= 12; d += 4) begin
            cfg_auto_en = '1;
            cfg_wait = {WW'(0), WW'(w)};
            run_cycle(2'b10, d, 0, 0, first, cnt);
            exp = (w + 1 < d + 2) ? w + 1 : d + 2;
            chk(first == exp, "R6 earliest termination", first, exp);
            chk(cnt == 1, "R4 R6 single pulse", cnt, 1);
         end
      end

      // R7: chip select released before completion aborts the cycle.
      cfg_auto_en = '1;
      cfg_wait = {WW'(0), WW'(10)};
      run_cycle(2'b10, 0, 3, 0, first, cnt);
      chk(cnt == 0, "R7 abort no done", cnt, 0);
      cfg_wait = {WW'(0), WW'(2)};
      run_cycle(2'b10, 0, 0, 0, first, cnt);
      chk(first == 3, "R7 fresh count after abort", first, 3);

      // R8: external acknowledge while idle.
      cnt = 0;
      @(negedge clk);
      ext_ack_n = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (cyc_done) cnt++;
      end
      ext_ack_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(cnt == 0, "R8 idle ack ignored", cnt, 0);

      // R2: lowest-numbered select wins when both are low.
      cfg_auto_en = '1;
      cfg_wait = {WW'(9), WW'(3)};
      run_cycle(2'b00, 0, 0, 0, first, cnt);
      chk(first == 4, "R2 priority region 0", first, 4);

      // R2: strobe with no select asserted does nothing.
      cfg_wait = '0;
      run_cycle(2'b11, 0, 0, 0, first, cnt);
      chk(cnt == 0, "R2 no select ignored", cnt, 0);

      // R9: strobe during a busy cycle is ignored.
      cfg_wait = {WW'(5), WW'(0)};
      run_cycle(2'b01, 0, 0, 2, first, cnt);
      chk(first == 6, "R9 busy restart ignored", first, 6);
      chk(cnt == 1, "R9 R4 single pulse", cnt, 1);

      summary();
      $finish;
   end

endmodule